// File: doc/BRIEF.md
# Per-Pin Output Select Remapper

This block connects a set of peripheral signals to a set of remappable device pins, in any combination, under control of configuration registers. Each pin owns a small code field that names the peripheral output that drives the pin and supplies its output enable. Each peripheral input function owns an index field that names the single pin it listens to. Pins whose code names no peripheral fall back to the general-purpose output value and enable for that pin.

Because each pin stores exactly one code, two peripheral outputs can never fight over a pin. Because each input function stores exactly one pin index, two pins can never drive one input. The same output code may still sit in several pin fields, so one peripheral output can be copied onto many pins, and several input functions may name the same pin. Configuration is written and read back through a synchronous address/data port. Pin outputs are registered. Pin inputs pass through a two-flop synchronizer before they are routed.

Top module: `pin_route_matrix`

## Requirements
- R1: After reset, every configuration field reads as 0, and pin_out, pin_oe, periph_din and cfg_rdata are all 0.
- R2: Address p (0 to 7) holds the 4-bit output code of pin p. Address 8+f (8 to 13) holds the 3-bit pin index of input function f: only the low 3 bits of a write are stored, and a read returns them zero-extended. cfg_rdata shows the field at cfg_addr one clock edge after the address is presented.
- R3: When a pin's code is 0, pin_out[p] follows gpio_dout[p] and pin_oe[p] follows gpio_oe[p].
- R4: When a pin's code k is in the range 1 to 9, pin_out[p] follows periph_dout[k-1] and pin_oe[p] follows periph_oe[k-1]. For example, code 3 selects periph_dout[2] (the serial-port transmit slot) and code 7 selects periph_dout[6] (the synchronous serial data-out slot).
- R5: Codes 10 to 15 behave exactly like code 0.
- R6: When the same code is written into several pin fields, every one of those pins carries the selected peripheral output and enable.
- R7: periph_din[f] carries pin_in[i], where i is the pin index stored for function f. Several functions may name the same pin.
- R8: pin_out and pin_oe reflect inputs and configuration sampled at the previous clock edge. A change on pin_in reaches periph_din on the third clock edge after it is sampled.
- R9: A configuration field changes only when it is written at its own address. Writes to addresses 14 and 15 change nothing, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration field address |
| cfg_wdata | input | 4 | Configuration write data |
| cfg_rdata | output | 4 | Registered read data for cfg_addr |
| gpio_dout | input | 8 | Fallback output value per pin |
| gpio_oe | input | 8 | Fallback output enable per pin |
| periph_dout | input | 9 | Peripheral outputs; bit k-1 is selected by code k |
| periph_oe | input | 9 | Peripheral output enables, indexed like periph_dout |
| pin_out | output | 8 | Registered value driven on each pin |
| pin_oe | output | 8 | Registered output enable of each pin |
| pin_in | input | 8 | Asynchronous pin input values |
| periph_din | output | 6 | Routed, synchronized input for each peripheral input function |

## Verification
The bench writes the same code into every pin, so that a design that decodes only the first matching pin, or leaves later pins on their fallback value, shows up at once. It writes codes above 9, which a design without range checking would turn into a selection of a missing or wrong peripheral bit. It writes all ones into an input-function field and reads back 7, which catches a field stored at full width. It also writes to the unmapped addresses, where an address decode that aliases them onto real fields would corrupt a pin. It samples periph_din one edge before and at the edge the synchronizer delay calls for, so a path with one flop too few or too many fails.

// File: rtl/pinroute_pkg.sv
package pinroute_pkg;

  function automatic int unsigned pr_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned pr_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/prt_cfg_regs.sv
module prt_cfg_regs #(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned N_IN   = 6,
  parameter int unsigned CODE_W = 4,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [DATA_W-1:0]                 rdata,
  output logic [N_PINS-1:0][CODE_W-1:0]     out_sel,
  output logic [N_IN-1:0][IDX_W-1:0]        in_sel
);

  localparam int unsigned N_FIELDS = N_PINS + N_IN;

  logic [DATA_W-1:0] rd_mux;

  // one register per pin: output function code
  for (genvar p = 0; p < N_PINS; p++) begin : g_pin_field
    logic hit;
    assign hit = we && (addr == ADDR_W'(p));

    always_ff @(posedge clk) begin
      if (rst)      out_sel[p] <= '0;
      else if (hit) out_sel[p] <= wdata[CODE_W-1:0];
    end

    // R9: untouched unless addressed
    a_r9_pin_field_hold: assert property (@(posedge clk) disable iff (rst)
      !(we && addr == ADDR_W'(p)) |=> $stable(out_sel[p]));
  end

  // one register per input function: source pin index
  for (genvar f = 0; f < N_IN; f++) begin : g_fn_field
    logic hit;
    assign hit = we && (addr == ADDR_W'(N_PINS + f));

    always_ff @(posedge clk) begin
      if (rst)      in_sel[f] <= '0;
      else if (hit) in_sel[f] <= wdata[IDX_W-1:0];
    end

    a_r9_fn_field_hold: assert property (@(posedge clk) disable iff (rst)
      !(we && addr == ADDR_W'(N_PINS + f)) |=> $stable(in_sel[f]));
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < N_PINS; p++)
      if (addr == ADDR_W'(p)) rd_mux[CODE_W-1:0] = out_sel[p];
    for (int f = 0; f < N_IN; f++)
      if (addr == ADDR_W'(N_PINS + f)) rd_mux[IDX_W-1:0] = in_sel[f];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  // R2/R9: unmapped addresses read as zero
  a_r2_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (int'(addr) >= N_FIELDS) |=> (rdata == '0));

endmodule

// File: rtl/prt_out_mux.sv
module prt_out_mux #(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned CODE_W = 4,
  parameter int unsigned N_FN   = 9
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_PINS-1:0][CODE_W-1:0] sel,
  input  logic [N_PINS-1:0]             gpio_dout,
  input  logic [N_PINS-1:0]             gpio_oe,
  input  logic [N_FN-1:0]               fn_dout,
  input  logic [N_FN-1:0]               fn_oe,
  output logic [N_PINS-1:0]             pin_out,
  output logic [N_PINS-1:0]             pin_oe
);

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic nxt_out;
    logic nxt_oe;

    always_comb begin
      nxt_out = gpio_dout[p];
      nxt_oe  = gpio_oe[p];
      for (int k = 1; k <= N_FN; k++) begin
        if (sel[p] == CODE_W'(k)) begin
          nxt_out = fn_dout[k-1];
          nxt_oe  = fn_oe[k-1];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out[p] <= 1'b0;
        pin_oe[p]  <= 1'b0;
      end else begin
        pin_out[p] <= nxt_out;
        pin_oe[p]  <= nxt_oe;
      end
    end

    // R3: code zero gives the general-purpose value
    a_r3_gpio_fallback: assert property (@(posedge clk) disable iff (rst)
      (sel[p] == '0) |=> (pin_out[p] == $past(gpio_dout[p]) && pin_oe[p] == $past(gpio_oe[p])));

    // R5: codes above the function count act as code zero
    a_r5_out_of_range: assert property (@(posedge clk) disable iff (rst)
      (int'(sel[p]) > N_FN) |=> (pin_out[p] == $past(gpio_dout[p]) && pin_oe[p] == $past(gpio_oe[p])));

    // R4/R8: valid code routes the named peripheral one edge later
    a_r4_periph_route: assert property (@(posedge clk) disable iff (rst)
      (sel[p] != '0 && int'(sel[p]) <= N_FN)
        |=> (pin_out[p] == $past(fn_dout[sel[p] - CODE_W'(1)])
             && pin_oe[p] == $past(fn_oe[sel[p] - CODE_W'(1)])));
  end

endmodule

// File: rtl/prt_in_sync.sv
module prt_in_sync #(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned N_IN   = 6,
  parameter int unsigned IDX_W  = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_PINS-1:0]           pin_in,
  input  logic [N_IN-1:0][IDX_W-1:0]  sel,
  output logic [N_IN-1:0]             fn_din
);

  logic [N_PINS-1:0] meta_q;
  logic [N_PINS-1:0] sync_q;
  logic [1:0]        warm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      warm_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end
  end

  for (genvar f = 0; f < N_IN; f++) begin : g_fn
    logic nxt;
    always_comb begin
      nxt = 1'b0;
      if (int'(sel[f]) < N_PINS) nxt = sync_q[sel[f]];
    end

    always_ff @(posedge clk) begin
      if (rst) fn_din[f] <= 1'b0;
      else     fn_din[f] <= nxt;
    end
  end

  // R8: every pin reaches the synchronized stage two edges after sampling
  for (genvar p = 0; p < N_PINS; p++) begin : g_chk
    a_r8_sync_depth: assert property (@(posedge clk) disable iff (rst)
      (warm_q == 2'd3) |-> (sync_q[p] == $past(pin_in[p], 2)));
  end

endmodule

// File: rtl/pin_route_matrix.sv
module pin_route_matrix
  import pinroute_pkg::*;
#(
  parameter int unsigned N_PINS     = 8,
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned N_OUT_FN   = 9,
  parameter int unsigned N_IN_FN    = 6,
  localparam int unsigned IDX_W     = pr_bits(N_PINS),
  localparam int unsigned ADDR_W    = pr_bits(N_PINS + N_IN_FN),
  localparam int unsigned DATA_W    = pr_max(CODE_W, IDX_W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [DATA_W-1:0]    cfg_rdata,
  input  logic [N_PINS-1:0]    gpio_dout,
  input  logic [N_PINS-1:0]    gpio_oe,
  input  logic [N_OUT_FN-1:0]  periph_dout,
  input  logic [N_OUT_FN-1:0]  periph_oe,
  output logic [N_PINS-1:0]    pin_out,
  output logic [N_PINS-1:0]    pin_oe,
  input  logic [N_PINS-1:0]    pin_in,
  output logic [N_IN_FN-1:0]   periph_din
);

  logic [N_PINS-1:0][CODE_W-1:0] out_sel;
  logic [N_IN_FN-1:0][IDX_W-1:0] in_sel;

  prt_cfg_regs #(
    .N_PINS(N_PINS), .N_IN(N_IN_FN), .CODE_W(CODE_W),
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata),
    .out_sel(out_sel), .in_sel(in_sel)
  );

  prt_out_mux #(
    .N_PINS(N_PINS), .CODE_W(CODE_W), .N_FN(N_OUT_FN)
  ) omux_i (
    .clk(clk), .rst(rst), .sel(out_sel),
    .gpio_dout(gpio_dout), .gpio_oe(gpio_oe),
    .fn_dout(periph_dout), .fn_oe(periph_oe),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  prt_in_sync #(
    .N_PINS(N_PINS), .N_IN(N_IN_FN), .IDX_W(IDX_W)
  ) isync_i (
    .clk(clk), .rst(rst), .pin_in(pin_in), .sel(in_sel), .fn_din(periph_din)
  );

  // R1: nothing is driven while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (pin_oe == '0 && pin_out == '0 && periph_din == '0));

endmodule

// File: tb/pin_route_matrix_tb_top.sv
module pin_route_matrix_tb_top;

  localparam int NP = 8;
  localparam int NO = 9;
  localparam int NI = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [3:0] cfg_wdata = '0;
  logic [3:0] cfg_rdata;
  logic [NP-1:0] gpio_dout = '0, gpio_oe = '0;
  logic [NO-1:0] periph_dout = '0, periph_oe = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic [NP-1:0] pin_in = '0;
  logic [NI-1:0] periph_din;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10ns clk = ~clk;

  pin_route_matrix dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .gpio_dout(gpio_dout), .gpio_oe(gpio_oe),
    .periph_dout(periph_dout), .periph_oe(periph_oe),
    .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_in(pin_in), .periph_din(periph_din)
  );

  // cfg (pin p code at [4p+3:4p]), gpio_dout, gpio_oe, periph_dout, periph_oe
  localparam logic [65:0] VEC [6] = '{
    {32'h0000_0000, 8'hA5, 8'h3C, 9'h155, 9'h0CA},
    {32'h7777_7777, 8'h00, 8'h00, 9'h040, 9'h040},
    {32'h3333_3333, 8'hFF, 8'h00, 9'h1FB, 9'h004},
    {32'h9876_5432, 8'h0F, 8'hF0, 9'h0AA, 9'h133},
    {32'hFEDC_BA00, 8'h96, 8'h69, 9'h1FF, 9'h1FF},
    {32'h0307_3070, 8'h5A, 8'hC3, 9'h044, 9'h1BB}
  };

  function automatic logic [1:0] model_pin(input logic [3:0] code, input logic gd, input logic ge,
                                           input logic [NO-1:0] pd, input logic [NO-1:0] pe);
    if (code >= 4'd1 && code <= 4'd9) return {pe[code-1], pd[code-1]};
    return {ge, gd};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [3:0] d);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [3:0] d);
    cfg_addr = 4'(a);
    @(posedge clk); @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic load_pins(input logic [31:0] c);
    for (int p = 0; p < NP; p++) wr(p, c[4*p +: 4]);
  endtask

  task automatic check_pins(input string req, input logic [31:0] c);
    logic [NP-1:0] eo, ee;
    for (int p = 0; p < NP; p++)
      {ee[p], eo[p]} = model_pin(c[4*p +: 4], gpio_dout[p], gpio_oe[p], periph_dout, periph_oe);
    chk({req, " pin_out"}, 32'(pin_out), 32'(eo));
    chk({req, " pin_oe"}, 32'(pin_oe), 32'(ee));
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [3:0] d;
    logic [31:0] cfg;
    logic [NI-1:0][2:0] isel;
    logic [NI-1:0] edin;
    logic [NI-1:0] old_din;
    void'($urandom(32'd7315));

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 pin_out", 32'(pin_out), 0);
    chk("R1 pin_oe", 32'(pin_oe), 0);
    chk("R1 periph_din", 32'(periph_din), 0);
    chk("R1 cfg_rdata", 32'(cfg_rdata), 0);
    for (int a = 0; a < NP + NI; a++) begin
      rd(a, d);
      chk("R1 field", 32'(d), 0);
    end

    // table of vectors: R3 R4 R5 R6
    for (int v = 0; v < 6; v++) begin
      cfg = VEC[v][65:34];
      load_pins(cfg);
      gpio_dout = VEC[v][33:26]; gpio_oe = VEC[v][25:18];
      periph_dout = VEC[v][17:9]; periph_oe = VEC[v][8:0];
      @(posedge clk); @(negedge clk);
      check_pins($sformatf("R3/R4/R5/R6 vec%0d", v), cfg);
    end

    // R2: readback of last pin config
    for (int p = 0; p < NP; p++) begin
      rd(p, d);
      chk("R2 pin field readback", 32'(d), 32'(VEC[5][34 + 4*p +: 4]));
    end

    // R6: serial transmit code on every pin, toggled
    load_pins(32'h3333_3333);
    periph_dout = 9'h004; periph_oe = 9'h004; gpio_dout = '0; gpio_oe = '0;
    @(posedge clk); @(negedge clk);
    chk("R6 all pins carry code 3", 32'(pin_out), 32'hFF);
    chk("R6 all pins enabled", 32'(pin_oe), 32'hFF);

    // R8: output latency, one edge
    periph_dout = 9'h000;
    chk("R8 pin_out before edge", 32'(pin_out), 32'hFF);
    @(posedge clk); @(negedge clk);
    chk("R8 pin_out after edge", 32'(pin_out), 32'h00);

    // R5: all out-of-range codes
    for (int c = 10; c < 16; c++) begin
      load_pins({8{4'(c)}});
      gpio_dout = 8'(c * 37); gpio_oe = 8'(c * 91);
      periph_dout = '1; periph_oe = '1;
      @(posedge clk); @(negedge clk);
      check_pins($sformatf("R5 code %0d", c), {8{4'(c)}});
    end

    // random output configurations: R3 R4 R6
    for (int i = 0; i < 40; i++) begin
      cfg = $urandom();
      load_pins(cfg);
      gpio_dout = 8'($urandom()); gpio_oe = 8'($urandom());
      periph_dout = 9'($urandom()); periph_oe = 9'($urandom());
      @(posedge clk); @(negedge clk);
      check_pins("R4 random", cfg);
    end

    // R2: input field keeps three bits
    wr(8 + 2, 4'hF);
    rd(8 + 2, d);
    chk("R2 input field width", 32'(d), 32'h7);

    // R9: unmapped writes ignored, read as zero
    load_pins(32'h1234_5678);
    wr(14, 4'h9); wr(15, 4'hC);
    rd(14, d); chk("R9 addr14 reads zero", 32'(d), 0);
    rd(15, d); chk("R9 addr15 reads zero", 32'(d), 0);
    for (int p = 0; p < NP; p++) begin
      rd(p, d);
      chk("R9 pin field unchanged", 32'(d), 32'(4'((32'h1234_5678 >> (4*p)))));
    end
    rd(8 + 2, d); chk("R9 fn field unchanged", 32'(d), 32'h7);

    // R7: random input routing, several functions may share a pin
    for (int i = 0; i < 30; i++) begin
      for (int f = 0; f < NI; f++) begin
        isel[f] = (i % 5 == 0) ? 3'(i) : 3'($urandom());
        wr(8 + f, {1'b0, isel[f]});
      end
      pin_in = 8'($urandom());
      repeat (3) @(posedge clk);
      @(negedge clk);
      for (int f = 0; f < NI; f++) edin[f] = pin_in[isel[f]];
      chk("R7 input routing", 32'(periph_din), 32'(edin));
    end

    // R8: input latency is three edges
    for (int f = 0; f < NI; f++) wr(8 + f, 3'(f + 1));
    pin_in = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    old_din = periph_din;
    chk("R8 input settled low", 32'(old_din), 0);
    pin_in = 8'hFF;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R8 input not yet after two edges", 32'(periph_din), 0);
    @(posedge clk); @(negedge clk);
    chk("R8 input after three edges", 32'(periph_din), 32'h3F);

    done = 1;
    summary();
  end

endmodule